// File: doc/BRIEF.md
# Privileged Interrupt Selection Unit

This block decides, from the current architectural interrupt state, whether the hart must take an interrupt now and which one. It receives the pending-source vector, the per-source enable vector, the per-source delegation mask, the current privilege level and the two global enables: one for machine level and one for supervisor level. It produces a take strobe and a cause word. The cause word carries the winning source index in its low bits and has its most significant bit set, which marks the cause as an interrupt rather than an exception.

Each source is gated by the level that owns it. A source whose delegation bit is clear belongs to machine level, and a source whose delegation bit is set belongs to supervisor level. A source may fire when the hart runs below the level that owns it, or when the hart runs at that level with the matching global enable set. Among the sources that may fire, the lowest-numbered one wins. The outputs can pass through an optional register stage, selected by a parameter, so that the unit can sit on a timing-critical path into trap entry.

Top module: `irq_select_unit`

## Requirements
- R1: A source is a candidate only when both its pending bit and its enable bit are 1. A source that lacks either bit is never taken, whatever the delegation bit, the privilege level or the global enables are.
- R2: A non-delegated candidate (delegation bit 0) is eligible when the privilege level is not machine (code 3). At machine level it is eligible only when the machine global enable is 1. The machine global enable has no effect at any other level.
- R3: A delegated candidate (delegation bit 1) is eligible at user level (code 0) whatever the supervisor global enable is. At supervisor level (code 1) it is eligible only when the supervisor global enable is 1. It is never eligible at machine level.
- R4: When several sources are eligible, the one with the lowest bit index is selected.
- R5: When a source is selected, take_o is 1 and cause_o holds the selected index in its low bits, with bit XLEN-1 set and every other bit 0.
- R6: When no source is eligible, take_o is 0 and cause_o is all zeros.
- R7: With REG_OUT=1, the outputs show the decision for the inputs sampled at the previous rising clock edge. Reset drives take_o and cause_o to 0.
- R8: The privilege level uses 2 bits: 0 user, 1 supervisor, 2 reserved, 3 machine. Level 2 counts as below machine, so non-delegated candidates are eligible there regardless of the machine global enable. Level 2 also counts as above supervisor, so delegated candidates are never eligible there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pend_i | input | NSRC | Pending bit for each source |
| en_i | input | NSRC | Enable bit for each source |
| deleg_i | input | NSRC | 1 = source owned by supervisor level, 0 = owned by machine level |
| priv_i | input | 2 | Current privilege level: 0 user, 1 supervisor, 2 reserved, 3 machine |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt must be taken |
| cause_o | output | XLEN | Cause word: bit XLEN-1 set, winning index in the low bits |

## Verification
The hardest situation to reach is one where two gates disagree inside a single vector. In that case a lower-numbered source is pending and enabled but blocked by its own level's gate, and a higher-numbered source owned by the other level must win. Directed vectors build exactly this case: a blocked delegated bit 1 sits under an open machine-owned bit 2, and the same is done at the reserved level. A long run of random vectors then mixes the delegation masks, the privilege levels and the two global enables. Every vector is checked against a model written from the requirements.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] deleg_i,
  input  priv_e           priv_i,
  input  logic            m_gie_i,
  input  logic            s_gie_i,
  output logic [NSRC-1:0] elig_o
);

  logic [NSRC-1:0] cand;
  logic            mach_open;
  logic            sup_open;

  always_comb begin
    cand      = pend_i & en_i;
    mach_open = (priv_i != PRIV_MACH) || m_gie_i;
    sup_open  = (priv_i == PRIV_USER) || ((priv_i == PRIV_SUPER) && s_gie_i);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_comb begin
      if (deleg_i[g]) elig_o[g] = cand[g] & sup_open;
      else            elig_o[g] = cand[g] & mach_open;
    end
  end

endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter int NSRC = 16,
  parameter int IW   = 4
) (
  input  logic [NSRC-1:0] req_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    valid_o = |req_i;
  end

endmodule

// File: rtl/irq_cause_stage.sv
module irq_cause_stage #(
  parameter int XLEN    = 32,
  parameter int IW      = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [IW-1:0]   idx_i,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o
);

  localparam int PADW = XLEN - 1 - IW;

  logic [XLEN-1:0] cause_nxt;

  always_comb begin
    if (valid_i) cause_nxt = {1'b1, {PADW{1'b0}}, idx_i};
    else         cause_nxt = '0;
  end

  if (REG_OUT) begin : g_reg
    logic            take_q;
    logic [XLEN-1:0] cause_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        take_q  <= 1'b0;
        cause_q <= '0;
      end else begin
        take_q  <= valid_i;
        cause_q <= cause_nxt;
      end
    end
    assign take_o  = take_q;
    assign cause_o = cause_q;

    AST_REG_TAKE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> take_o);  // R7
    AST_REG_TAKE_LO: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> !take_o);  // R7
  end else begin : g_comb
    assign take_o  = valid_i;
    assign cause_o = cause_nxt;
  end

endmodule

// File: rtl/irq_select_unit.sv
module irq_select_unit
  import irq_sel_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NSRC    = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            m_gie_i,
  input  logic            s_gie_i,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o
);

  localparam int IW = idx_width(NSRC);

  logic [NSRC-1:0] elig;
  logic            pick_valid;
  logic [IW-1:0]   pick_idx;
  priv_e           priv;

  assign priv = priv_e'(priv_i);

  irq_gate #(.NSRC(NSRC)) u_gate (
    .pend_i  (pend_i),
    .en_i    (en_i),
    .deleg_i (deleg_i),
    .priv_i  (priv),
    .m_gie_i (m_gie_i),
    .s_gie_i (s_gie_i),
    .elig_o  (elig)
  );

  irq_lsb_pick #(.NSRC(NSRC), .IW(IW)) u_pick (
    .req_i   (elig),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  irq_cause_stage #(.XLEN(XLEN), .IW(IW), .REG_OUT(REG_OUT)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (pick_valid),
    .idx_i   (pick_idx),
    .take_o  (take_o),
    .cause_o (cause_o)
  );

  AST_ELIG_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (elig & ~(pend_i & en_i)) == '0);  // R1
  AST_MACH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd3 && !m_gie_i) |-> (elig & ~deleg_i) == '0);  // R2
  AST_SUP_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i[1] || (priv_i == 2'd1 && !s_gie_i)) |-> (elig & deleg_i) == '0);  // R3
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (elig[pick_idx] && ((elig & ((NSRC'(1) << pick_idx) - NSRC'(1))) == '0)));  // R4
  AST_CAUSE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (cause_o[XLEN-1] && cause_o[XLEN-2:IW] == '0));  // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> cause_o == '0);  // R6

endmodule

// File: tb/irq_select_unit_test.sv
`timescale 1ns/1ps
module irq_select_unit_test;

  localparam int XLEN = 32;
  localparam int NSRC = 16;

  typedef struct {
    logic            take;
    logic [XLEN-1:0] cause;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] pend = '0, en = '0, deleg = '0;
  logic [1:0]      priv = 2'd0;
  logic            mg = 1'b0, sg = 1'b0;
  logic            take_o;
  logic [XLEN-1:0] cause_o;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;

  irq_select_unit #(.XLEN(XLEN), .NSRC(NSRC), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .m_gie_i(mg), .s_gie_i(sg), .take_o(take_o), .cause_o(cause_o)
  );

  task automatic check(input string tag, input logic t, input logic [XLEN-1:0] c,
                       input logic et, input logic [XLEN-1:0] ec);
    checks++;
    if (t !== et || c !== ec) begin
      fails++;
      $display("FAIL %s take=%0b cause=%h expected take=%0b cause=%h", tag, t, c, et, ec);
    end
  endtask

  task automatic drive(input logic [NSRC-1:0] p, input logic [NSRC-1:0] e,
                       input logic [NSRC-1:0] d, input logic [1:0] pv,
                       input logic m, input logic s, input string tag);
    exp_t x;
    x.take  = 1'b0;
    x.cause = '0;
    x.tag   = tag;
    for (int i = 0; i < NSRC; i++) begin
      bit ok;
      if (!(p[i] && e[i])) ok = 0;
      else if (d[i]) ok = (pv == 2'd0) || (pv == 2'd1 && s);
      else ok = (pv != 2'd3) || m;
      if (ok && !x.take) begin
        x.take  = 1'b1;
        x.cause = (XLEN'(1) << (XLEN - 1)) | XLEN'(i);
      end
    end
    @(negedge clk);
    pend = p; en = e; deleg = d; priv = pv; mg = m; sg = s;
    q.push_back(x);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        check(x.tag, take_o, cause_o, x.take, x.cause);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R7 reset", take_o, cause_o, 1'b0, '0);
    rst_n = 1'b1;
    drive(16'h0010, 16'h0000, 16'h0000, 2'd3, 1, 1, "R1 pending not enabled");
    drive(16'h0000, 16'h0010, 16'h0000, 2'd0, 1, 1, "R1 enabled not pending");
    drive(16'h0010, 16'h0010, 16'h0000, 2'd3, 1, 0, "R2 machine open");
    drive(16'h0010, 16'h0010, 16'h0000, 2'd3, 0, 1, "R2 machine closed");
    drive(16'h0010, 16'h0010, 16'h0000, 2'd1, 0, 0, "R2 below machine");
    drive(16'h0010, 16'h0010, 16'h0010, 2'd3, 1, 1, "R3 delegated at machine");
    drive(16'h0010, 16'h0010, 16'h0010, 2'd1, 1, 0, "R3 supervisor closed");
    drive(16'h0010, 16'h0010, 16'h0010, 2'd1, 0, 1, "R3 supervisor open");
    drive(16'h0010, 16'h0010, 16'h0010, 2'd0, 0, 0, "R3 user level");
    drive(16'h0020, 16'h0020, 16'h0000, 2'd2, 0, 0, "R8 reserved nondelegated");
    drive(16'h0020, 16'h0020, 16'h0020, 2'd2, 1, 1, "R8 reserved delegated");
    drive(16'h0006, 16'h0006, 16'h0002, 2'd2, 0, 1, "R8 reserved mixed");
    drive(16'h8421, 16'hFFFF, 16'h0000, 2'd0, 0, 0, "R4 lowest of four");
    drive(16'h8420, 16'hFFFF, 16'h0000, 2'd0, 0, 0, "R4 lowest of three");
    drive(16'h8000, 16'h8000, 16'h0000, 2'd3, 1, 0, "R5 top source index");
    drive(16'h0001, 16'h0001, 16'h0000, 2'd3, 1, 0, "R5 index zero");
    drive(16'h0006, 16'h0006, 16'h0002, 2'd3, 1, 1, "R4 blocked lower delegated");
    drive(16'h0000, 16'h0000, 16'h0000, 2'd0, 1, 1, "R6 nothing pending");
    drive(16'hFFFF, 16'hFFFF, 16'hFFFF, 2'd3, 1, 1, "R6 all delegated at machine");
    for (int n = 0; n < 300; n++) begin
      drive(NSRC'($urandom), NSRC'($urandom), NSRC'($urandom), 2'($urandom),
            1'($urandom), 1'($urandom), "R2/R3/R4 random");
    end
    @(negedge clk);
    pend = '0; en = '0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule